// File: doc/BRIEF.md
# CAN Arbitrating Bit-Stuffing Transmitter

This block sends one base-format CAN data frame, one bit per bit-time. A single-cycle start pulse captures an 11-bit identifier, a 4-bit data length code and up to eight data bytes. From then on the block ignores its inputs until the frame ends. The block drives a transmit line and reads back the wired-AND bus. Logic 0 is dominant: any node that drives 0 pulls the bus to 0.

While the identifier goes out, the block compares each bus sample with the bit it drove. If it drove recessive and reads dominant, another node with a smaller identifier has priority. The block then releases the line at once and raises a lost flag. This leaves the winning frame intact.

The block inserts a complementary stuff bit after every run of five equal bits, from start-of-frame up to the end of the CRC. It computes a CRC-15 on the fly. It samples the acknowledge slot and flags a missing acknowledge. A bit-time enable tick, supplied from outside, paces every bit.

Top module: `can_frame_tx`

## Requirements
- R1: During and after reset, with no frame in progress, `tx_out` is 1 (recessive) and `busy`, `done`, `lost` and `ack_missing` are 0.
- R2: A `start` pulse seen while idle captures `ident`, `dlc` and `payload`. On the next clock `busy` is 1 and `tx_out` is 0 (start-of-frame). A `start` seen while `busy` is 1 has no effect on the frame being sent.
- R3: The unstuffed bits are sent in this order. First a 0 start-of-frame bit. Then the 11 identifier bits, most significant first. Then three 0 bits (remote-request, extended-format, reserved). Then the 4 `dlc` bits, most significant first. Then the data bytes: byte 0 is `payload[63:56]`, each byte sent most significant bit first.
- R4: The number of data bytes sent is `dlc` when `dlc` is 0 to 8, and 8 when `dlc` is 9 to 15. The `dlc` field itself is always sent as it was captured.
- R5: From start-of-frame up to the last CRC bit, five consecutive equal bits are followed by one inserted bit of the opposite level. The inserted bit starts a new run. This includes an insertion that falls due right after the last CRC bit.
- R6: Fifteen CRC bits follow the data, most significant first. The CRC is the remainder over the unstuffed bits from start-of-frame through the last data bit, with generator 0x4599 and a start value of 0.
- R7: After the CRC come ten unstuffed recessive bits: the CRC delimiter, the acknowledge slot, the acknowledge delimiter and seven end-of-frame bits.
- R8: Arbitration uses the identifier bits only (not inserted bits). If the block sent 1 on such a bit and samples 0, then `tx_out` is 1 from the next bit on, `busy` drops and `lost` rises. `done` stays 0.
- R9: If the bus matches every identifier bit sent, the frame runs to its end and `done` rises. When two frames start together, the smaller identifier wins (0x10F beats 0x120).
- R10: If the bus reads 1 in the acknowledge slot, `ack_missing` rises. The frame still completes end-of-frame and raises `done`.
- R11: The bus is sampled, and the next bit driven, only on clocks where `bit_tick` is 1. Between ticks `tx_out` does not change.
- R12: `done`, `lost` and `ack_missing` keep their values until the next accepted `start`, which clears all three. `done` and `lost` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit-time; the bus is sampled and the next bit launched on it |
| start | input | 1 | Begin a frame (accepted only while idle) |
| ident | input | 11 | Frame identifier |
| dlc | input | 4 | Data length code |
| payload | input | 64 | Data bytes, byte 0 in bits 63:56 |
| bus_rx | input | 1 | Sampled wired-AND bus level |
| tx_out | output | 1 | Transmit line, 0 dominant |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Last frame completed |
| lost | output | 1 | Last frame lost arbitration |
| ack_missing | output | 1 | No dominant acknowledge seen in last frame |

## Verification
The bench races a second transmitter against the block. It uses identifiers that agree up to a late bit, so a design that compares too early, compares on inserted bits, or keeps driving after losing would corrupt the winner or flag the wrong outcome. All-zero and all-one identifier and data patterns force stuff bits at field boundaries and straight after the last CRC bit. A design that miscounted runs, or stopped stuffing one bit early, shifts every later bit and fails the per-cycle comparison. A length code above eight, a missing acknowledge, and a start pulse in mid-frame check that the byte count is clamped, that the frame still completes without an acknowledge, and that inputs are held from the start pulse.

// File: rtl/can_tx_pkg.sv
`timescale 1ns/1ps
// Shared constants for the frame transmitter.
// Assumes the base (11-bit identifier) frame format only.
package can_tx_pkg;
    localparam int ID_BITS    = 11;
    localparam int LEN_BITS   = 4;
    localparam int CRC_BITS   = 15;
    localparam logic [CRC_BITS-1:0] CRC_GEN = 15'h4599;
    localparam int RUN_LIMIT  = 5;
    localparam int EOF_BITS   = 7;
    localparam int CTRL_ZEROS = 3;    // remote-request, extended-format, reserved
    localparam int TAIL_BITS  = 3 + EOF_BITS; // crc delimiter, ack slot, ack delimiter, eof
endpackage

// File: rtl/can_crc15.sv
`timescale 1ns/1ps
// Serial CRC generator, one bit per step.
// Assumes the caller steps it only on unstuffed bits up to the last data bit.
// crc_next is a look-ahead: the value the register will hold after this clock.
module can_crc15 #(
    parameter int CRC_W = 15,
    parameter logic [CRC_W-1:0] GEN = 15'h4599
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_next
);
    logic [CRC_W-1:0] crc_q;
    logic             feedback;

    // Next remainder from the current bit and the top register bit
    always_comb begin
        feedback = bit_in ^ crc_q[CRC_W-1];
        if (step) begin
            crc_next = {crc_q[CRC_W-2:0], 1'b0} ^ (feedback ? GEN : '0);
        end else begin
            crc_next = crc_q;
        end
    end

    // Remainder register, zeroed at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clear) begin
            crc_q <= '0;
        end else begin
            crc_q <= crc_next;
        end
    end
endmodule

// File: rtl/can_stuff_monitor.sv
`timescale 1ns/1ps
// Tracks the run of equal bits on the line inside the stuffed region.
// Assumes step is raised once per transmitted bit (stuff bits included).
// stuff_due says the bit now being sent completes a run of RUN_LEN.
module can_stuff_monitor #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic bit_in,
    output logic stuff_due
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             lvl_q;

    // Run length including the bit now being sent
    always_comb begin
        if (cnt_q != '0 && bit_in == lvl_q) begin
            cnt_nxt = cnt_q + 1'b1;
        end else begin
            cnt_nxt = CNT_W'(1);
        end
        stuff_due = step && (cnt_nxt == CNT_LIMIT);
    end

    // Run counter and level of the last bit sent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (clear) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (step) begin
            cnt_q <= cnt_nxt;
            lvl_q <= bit_in;
        end
    end
endmodule

// File: rtl/can_bit_source.sv
`timescale 1ns/1ps
// Combinational lookup of the unstuffed frame bit at a given position.
// Assumes position 0 is start-of-frame, and that crc already holds the
// final remainder whenever pos points into the CRC field.
module can_bit_source
    import can_tx_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int POS_W     = 7
) (
    input  logic [POS_W-1:0]       pos,
    input  logic [POS_W-1:0]       data_end,
    input  logic [ID_BITS-1:0]     ident,
    input  logic [LEN_BITS-1:0]    dlc,
    input  logic [MAX_BYTES*8-1:0] payload,
    input  logic [CRC_BITS-1:0]    crc,
    output logic                   raw_bit
);
    localparam int HDR_W = 1 + ID_BITS + CTRL_ZEROS + LEN_BITS;
    localparam logic [POS_W-1:0] P_DATA0 = POS_W'(HDR_W);
    localparam logic [POS_W-1:0] P_CRCW  = POS_W'(CRC_BITS);

    logic [HDR_W-1:0]       hdr;
    logic [HDR_W-1:0]       hdr_sh;
    logic [MAX_BYTES*8-1:0] pl_sh;
    logic [CRC_BITS-1:0]    crc_sh;

    // Pick the field holding pos and shift the wanted bit to the top
    always_comb begin
        hdr    = {1'b0, ident, {CTRL_ZEROS{1'b0}}, dlc};
        hdr_sh = hdr << pos;
        pl_sh  = payload << (pos - P_DATA0);
        crc_sh = crc << (pos - data_end);
        if (pos < P_DATA0) begin
            raw_bit = hdr_sh[HDR_W-1];
        end else if (pos < data_end) begin
            raw_bit = pl_sh[MAX_BYTES*8-1];
        end else if (pos < data_end + P_CRCW) begin
            raw_bit = crc_sh[CRC_BITS-1];
        end else begin
            raw_bit = 1'b1;
        end
    end
endmodule

// File: rtl/can_frame_tx.sv
`timescale 1ns/1ps
// Base-format CAN data frame transmitter with identifier arbitration,
// bit stuffing and CRC-15.
// Assumes bit_tick pulses once per bit-time, at the point where bus_rx
// holds the settled sample of the bit currently driven. Inputs are
// captured on an accepted start and ignored until the frame ends.
module can_frame_tx
    import can_tx_pkg::*;
#(
    parameter int MAX_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_tick,
    input  logic                   start,
    input  logic [ID_BITS-1:0]     ident,
    input  logic [LEN_BITS-1:0]    dlc,
    input  logic [MAX_BYTES*8-1:0] payload,
    input  logic                   bus_rx,
    output logic                   tx_out,
    output logic                   busy,
    output logic                   done,
    output logic                   lost,
    output logic                   ack_missing
);
    localparam int HDR_W   = 1 + ID_BITS + CTRL_ZEROS + LEN_BITS;
    localparam int MAX_POS = HDR_W + 8 * MAX_BYTES + CRC_BITS + TAIL_BITS;
    localparam int POS_W   = $clog2(MAX_POS + 1);
    localparam logic [POS_W-1:0] P_ID0   = POS_W'(1);
    localparam logic [POS_W-1:0] P_CTRL0 = POS_W'(1 + ID_BITS);
    localparam logic [POS_W-1:0] P_DATA0 = POS_W'(HDR_W);
    localparam logic [POS_W-1:0] P_CRCW  = POS_W'(CRC_BITS);
    localparam logic [POS_W-1:0] P_LAST  = POS_W'(TAIL_BITS - 1);
    localparam logic [POS_W-1:0] P_MAXB  = POS_W'(MAX_BYTES);

    logic [ID_BITS-1:0]     ident_q;
    logic [LEN_BITS-1:0]    dlc_q;
    logic [MAX_BYTES*8-1:0] payload_q;
    logic [POS_W-1:0]       pos_q;
    logic                   is_stuff_q;
    logic                   tx_q, busy_q, done_q, lost_q, ackm_q;

    logic [POS_W-1:0]    dlc_ext, nbytes, data_end, crc_end, pos_sel;
    logic [CRC_BITS-1:0] crc_next;
    logic                accept, advance, in_stuff_zone, in_id, arb_loss;
    logic                at_ack, last_bit, crc_step, stuff_step, stuff_due, raw_next;

    // Field boundaries for the captured length code
    always_comb begin
        dlc_ext  = POS_W'(dlc_q);
        nbytes   = (dlc_ext > P_MAXB) ? P_MAXB : dlc_ext;
        data_end = P_DATA0 + (nbytes << 3);
        crc_end  = data_end + P_CRCW;
    end

    // Per-bit decisions taken at each tick
    always_comb begin
        accept        = !busy_q && start;
        advance       = busy_q && bit_tick;
        in_stuff_zone = is_stuff_q || (pos_q < crc_end);
        in_id         = !is_stuff_q && (pos_q >= P_ID0) && (pos_q < P_CTRL0);
        arb_loss      = advance && in_id && tx_q && !bus_rx;
        at_ack        = !is_stuff_q && (pos_q == crc_end + POS_W'(1));
        last_bit      = !is_stuff_q && (pos_q == crc_end + P_LAST);
        crc_step      = advance && !is_stuff_q && (pos_q < data_end);
        stuff_step    = advance && !arb_loss && in_stuff_zone;
        pos_sel       = is_stuff_q ? pos_q : pos_q + POS_W'(1);
    end

    can_crc15 #(
        .CRC_W (CRC_BITS),
        .GEN   (CRC_GEN)
    ) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .step     (crc_step),
        .bit_in   (tx_q),
        .crc_next (crc_next)
    );

    can_stuff_monitor #(
        .RUN_LEN (RUN_LIMIT)
    ) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .step      (stuff_step),
        .bit_in    (tx_q),
        .stuff_due (stuff_due)
    );

    can_bit_source #(
        .MAX_BYTES (MAX_BYTES),
        .POS_W     (POS_W)
    ) u_src (
        .pos      (pos_sel),
        .data_end (data_end),
        .ident    (ident_q),
        .dlc      (dlc_q),
        .payload  (payload_q),
        .crc      (crc_next),
        .raw_bit  (raw_next)
    );

    // Frame sequencer: capture, arbitration, stuffing and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ident_q    <= '0;
            dlc_q      <= '0;
            payload_q  <= '0;
            pos_q      <= '0;
            is_stuff_q <= 1'b0;
            tx_q       <= 1'b1;
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            lost_q     <= 1'b0;
            ackm_q     <= 1'b0;
        end else if (accept) begin
            ident_q    <= ident;
            dlc_q      <= dlc;
            payload_q  <= payload;
            pos_q      <= '0;
            is_stuff_q <= 1'b0;
            tx_q       <= 1'b0;
            busy_q     <= 1'b1;
            done_q     <= 1'b0;
            lost_q     <= 1'b0;
            ackm_q     <= 1'b0;
        end else if (advance) begin
            if (arb_loss) begin
                tx_q   <= 1'b1;
                busy_q <= 1'b0;
                lost_q <= 1'b1;
            end else begin
                if (at_ack && bus_rx) begin
                    ackm_q <= 1'b1;
                end
                if (last_bit) begin
                    tx_q   <= 1'b1;
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else if (stuff_due) begin
                    tx_q       <= ~tx_q;
                    is_stuff_q <= 1'b1;
                    pos_q      <= pos_q + POS_W'(1);
                end else begin
                    tx_q       <= raw_next;
                    is_stuff_q <= 1'b0;
                    pos_q      <= pos_sel;
                end
            end
        end
    end

    assign tx_out      = tx_q;
    assign busy        = busy_q;
    assign done        = done_q;
    assign lost        = lost_q;
    assign ack_missing = ackm_q;
endmodule

// File: rtl/can_frame_tx_chk.sv
`timescale 1ns/1ps
// Protocol checker for can_frame_tx, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module can_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic start,
    input logic bus_rx,
    input logic tx_out,
    input logic busy,
    input logic done,
    input logic lost
);
    // R1: an idle transmitter leaves the line recessive
    p_idle_recessive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_out);

    // R11: the driven bit only moves on a tick
    p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bit_tick |=> $stable(tx_out));

    // R2: a start during a frame leaves the frame running
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !bit_tick |=> busy);

    // R8: losing happens only on a recessive bit read back dominant
    p_lost_on_recessive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(tx_out) && !$past(bus_rx));

    // R8: after losing the node no longer drives the bus
    p_lost_withdraws_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> tx_out && !busy);

    // R12: the two outcomes exclude each other
    p_outcome_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && lost));

    // R7: the frame ends on a recessive end-of-frame bit
    p_done_after_recessive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(tx_out) && tx_out);
endmodule

bind can_frame_tx can_frame_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .start    (start),
    .bus_rx   (bus_rx),
    .tx_out   (tx_out),
    .busy     (busy),
    .done     (done),
    .lost     (lost)
);

// File: tb/tb_can_frame_tx.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural frame model plus a competing node
// and an acknowledging receiver, compared with the design every clock.
module tb_can_frame_tx;
    typedef bit frame_t [256];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        start = 1'b0;
    logic [10:0] ident = '0;
    logic [3:0]  dlc = '0;
    logic [63:0] payload = '0;
    logic        bus_rx;
    logic        tx_out, busy, done, lost, ack_missing;
    logic        comp_drive = 1'b1;
    logic        ack_drive  = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int tdiv     = 0;

    // model state
    frame_t d_bits, d_arb, d_ack, c_bits, c_arb, c_ack;
    int  d_len, d_idx, c_len, c_idx;
    bit  m_busy, m_done, m_lost, m_ackm, exp_tx, c_active;
    bit  ack_en, use_comp;
    logic [10:0] comp_id;

    always #2 clk = ~clk;

    assign bus_rx = tx_out & comp_drive & ack_drive;

    can_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start),
        .ident(ident), .dlc(dlc), .payload(payload), .bus_rx(bus_rx),
        .tx_out(tx_out), .busy(busy), .done(done), .lost(lost),
        .ack_missing(ack_missing)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected line bits of one frame, stuffing applied
    task automatic build(input logic [10:0] id, input logic [3:0] dl, input logic [63:0] pl,
                         output frame_t b, output frame_t ar, output frame_t ak, output int n);
        bit raw[$];
        int nb, cend, run;
        bit last, fb;
        logic [14:0] crc;
        for (int i = 0; i < 256; i++) begin b[i] = 1; ar[i] = 0; ak[i] = 0; end
        raw.push_back(1'b0);
        for (int i = 10; i >= 0; i--) raw.push_back(id[i]);
        for (int i = 0; i < 3; i++) raw.push_back(1'b0);
        for (int i = 3; i >= 0; i--) raw.push_back(dl[i]);
        nb = (dl > 8) ? 8 : int'(dl);
        for (int i = 0; i < nb * 8; i++) raw.push_back(pl[63 - i]);
        crc = '0;
        for (int i = 0; i < raw.size(); i++) begin
            fb = raw[i] ^ crc[14];
            crc = {crc[13:0], 1'b0};
            if (fb) crc = crc ^ 15'h4599;
        end
        for (int i = 14; i >= 0; i--) raw.push_back(crc[i]);
        cend = raw.size();
        for (int i = 0; i < 10; i++) raw.push_back(1'b1);
        n = 0; run = 0; last = 1;
        for (int k = 0; k < raw.size(); k++) begin
            b[n] = raw[k]; ar[n] = (k >= 1 && k <= 11); ak[n] = (k == cend + 1);
            n++;
            if (k < cend) begin
                if (run > 0 && raw[k] == last) run++; else run = 1;
                last = raw[k];
                if (run == 5) begin
                    b[n] = !raw[k]; n++; run = 1; last = !raw[k];
                end
            end
        end
    endtask

    // Bit-time tick: one clock in four
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        bit_tick <= (tdiv == 0);
    end

    // Reference model, advanced on the same edges as the design
    always @(posedge clk) begin
        bit pre, dbit, cbit, abit, bus;
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_lost = 0; m_ackm = 0; exp_tx = 1; c_active = 0;
        end else begin
            pre = m_busy;
            if (bit_tick && (m_busy || c_active)) begin
                dbit = m_busy ? d_bits[d_idx] : 1'b1;
                cbit = c_active ? c_bits[c_idx] : 1'b1;
                abit = !(ack_en && m_busy && d_ack[d_idx]);
                bus  = dbit & cbit & abit;
                if (m_busy) begin
                    if (d_arb[d_idx] && dbit && !bus) begin
                        m_busy = 0; m_lost = 1;
                    end else begin
                        if (d_ack[d_idx] && bus) m_ackm = 1;
                        d_idx++;
                        if (d_idx == d_len) begin m_busy = 0; m_done = 1; end
                    end
                end
                if (c_active) begin
                    if (c_arb[c_idx] && cbit && !bus) c_active = 0;
                    else begin
                        c_idx++;
                        if (c_idx == c_len) c_active = 0;
                    end
                end
            end
            if (!pre && start) begin
                build(ident, dlc, payload, d_bits, d_arb, d_ack, d_len);
                d_idx = 0; m_busy = 1; m_done = 0; m_lost = 0; m_ackm = 0;
                if (use_comp) begin
                    build(comp_id, 4'd1, 64'hA5 << 56, c_bits, c_arb, c_ack, c_len);
                    c_idx = 0; c_active = 1;
                end
            end
            exp_tx = m_busy ? d_bits[d_idx] : 1'b1;
        end
        comp_drive <= c_active ? c_bits[c_idx] : 1'b1;
        ack_drive  <= !(ack_en && m_busy && d_ack[d_idx]);
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(tx_out == exp_tx, "R3/R4/R5/R6/R7/R11 tx_out", tx_out, exp_tx);
            check(busy == m_busy, "R2/R8/R9 busy", busy, m_busy);
            check(done == m_done, "R9/R12 done", done, m_done);
            check(lost == m_lost, "R8/R12 lost", lost, m_lost);
            check(ack_missing == m_ackm, "R10 ack_missing", ack_missing, m_ackm);
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            check(0, "watchdog expired", cycles, 150000);
            summary();
            $finish;
        end
    end

    task automatic send(input logic [10:0] id, input logic [3:0] dl, input logic [63:0] pl,
                        input bit ack_on, input bit comp_on, input logic [10:0] cid);
        @(negedge clk);
        ident = id; dlc = dl; payload = pl; ack_en = ack_on;
        use_comp = comp_on; comp_id = cid; start = 1;
        @(negedge clk);
        start = 0;
        check(busy == 1, "R2 busy after start", busy, 1);
        while (m_busy || c_active) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        ack_en = 1; use_comp = 0; comp_id = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(tx_out == 1, "R1 tx_out in reset", tx_out, 1);
        check(busy == 0 && done == 0 && lost == 0 && ack_missing == 0, "R1 flags in reset",
              {busy, done, lost, ack_missing}, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check(tx_out == 1 && busy == 0, "R1 idle after reset", {tx_out, busy}, 2);

        // R3 R5 R6: long ones run in the identifier, mixed data
        send(11'h7F0, 4'd2, 64'h00FF_0000_0000_0000, 1, 0, '0);
        check(done == 1 && ack_missing == 0, "R9 frame completes", {done, ack_missing}, 2);
        // R12: flags hold while idle
        repeat (20) @(negedge clk);
        check(done == 1, "R12 done held", done, 1);

        // R5: all-zero identifier and no data, dense stuffing
        send(11'h000, 4'd0, 64'h0, 1, 0, '0);
        check(done == 1, "R5 zero frame done", done, 1);

        // R3 R6: full eight bytes
        send(11'h5A3, 4'd8, 64'h0123_4567_89AB_CDEF, 1, 0, '0);
        check(done == 1, "R3 eight byte frame", done, 1);

        // R4: length code above eight
        send(11'h2C1, 4'd12, 64'hFFFF_FFFF_0000_0000, 1, 0, '0);
        check(done == 1, "R4 clamped frame", done, 1);

        // R10: no acknowledge
        send(11'h333, 4'd1, 64'h3C00_0000_0000_0000, 0, 0, '0);
        check(ack_missing == 1 && done == 1, "R10 missing ack still done", {ack_missing, done}, 3);

        // R12: a new start clears the flags
        @(negedge clk);
        ident = 11'h444; dlc = 4'd0; ack_en = 1; use_comp = 0; start = 1;
        @(negedge clk);
        start = 0;
        check(done == 0 && ack_missing == 0, "R12 flags cleared", {done, ack_missing}, 0);
        // R2: start in mid-frame with other inputs is ignored
        repeat (40) @(negedge clk);
        ident = 11'h001; dlc = 4'd8; start = 1;
        @(negedge clk);
        start = 0;
        check(busy == 1, "R2 busy after mid-frame start", busy, 1);
        while (m_busy) @(negedge clk);
        repeat (8) @(negedge clk);
        check(done == 1, "R2 original frame done", done, 1);

        // R8: 0x120 against 0x10F loses
        send(11'h120, 4'd1, 64'h5500_0000_0000_0000, 1, 1, 11'h10F);
        check(lost == 1, "R8 lost raised", lost, 1);
        check(done == 0, "R8 no done after loss", done, 0);
        check(tx_out == 1, "R8 line released", tx_out, 1);

        // R9: 0x10F against 0x120 wins
        send(11'h10F, 4'd1, 64'h5500_0000_0000_0000, 1, 1, 11'h120);
        check(done == 1 && lost == 0, "R9 smaller identifier wins", {done, lost}, 2);

        // R9: identical prefix up to the last identifier bit
        send(11'h3FE, 4'd0, 64'h0, 1, 1, 11'h3FF);
        check(done == 1 && lost == 0, "R9 late difference wins", {done, lost}, 2);
        send(11'h3FF, 4'd0, 64'h0, 1, 1, 11'h3FE);
        check(lost == 1, "R8 late difference loses", lost, 1);

        summary();
        $finish;
    end
endmodule